// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Six-Flag Status Register

This block is a 32-bit integer arithmetic and logic unit. It performs eight operations: plain add, add with carry, plain subtract, subtract with borrow, AND, OR, XOR and compare. The result is combinational. Every operation also derives six status flags from its result: carry, parity, auxiliary carry, zero, sign and overflow. When the update enable is high, the block writes these flags into a status register on the rising clock edge.

The carry-in for the chained operations (add with carry, subtract with borrow) is not an input pin. It comes from the carry bit already held in the status register. A sequence of operations can therefore build wide arithmetic out of 32-bit slices. The compare operation runs a subtraction only to set the flags. Its numeric difference is never presented, and the result port shows the first operand unchanged.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 gives op_a+op_b, opcode 2 gives op_a-op_b, and opcode 1 and opcode 3 give op_a+op_b+C and op_a-op_b-C. In each case the result is truncated to WIDTH bits, and C is the stored carry flag (flags_o bit 0).
- R2: Opcodes 0 and 2 ignore the stored carry flag. Opcodes 1 and 3 use it as carry-in or borrow-in.
- R3: Flag bit 0 (carry) is set on an unsigned carry out of the top bit for additions, and on a borrow (op_a unsigned-less-than op_b plus borrow-in) for subtract, subtract-with-borrow and compare.
- R4: Flag bit 5 (overflow) is set for additions when both operands share a sign and the result's sign differs from it. For subtractions it is set when the operand signs differ and the result's sign differs from op_a's sign.
- R5: Flag bit 4 (sign) equals the result's top bit. Flag bit 3 (zero) is set when all result bits are 0.
- R6: Flag bit 2 (auxiliary) is the carry out of bit 3 into bit 4 for additions, or the borrow into bit 4 for subtractions.
- R7: Flag bit 1 (parity) is set when the low 8 result bits contain an even number of ones.
- R8: Opcodes 4 (AND), 5 (OR) and 6 (XOR) clear the carry, overflow and auxiliary flags, and set sign, zero and parity from the result.
- R9: Opcode 7 (compare) sets the flags as a subtraction would, and result_o carries op_a unchanged.
- R10: The flags register changes only on a clock edge with flag_we_i high. Otherwise it holds.
- R11: An active-low reset clears all six flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| opcode_i | input | 3 | Operation select |
| flag_we_i | input | 1 | Flag register update enable |
| result_o | output | WIDTH | Operation result (op_a for compare) |
| flags_o | output | 6 | {overflow, sign, zero, aux, parity, carry} |

## Verification
The bench targets operand pairs that separate unsigned carry from signed overflow, such as 0x7FFFFFFF+1 and 0x80000000 compared with 1. A design that swapped or merged the two flags would report the wrong one on these pairs. Carry chains through the stored flag are checked in both directions. An add-with-carry that drops the chained carry, or a plain add that wrongly uses it, returns a result that is off by one.

Results with ones in the upper bytes but a differing low-byte count catch parity computed over the whole word. Nibble borrows catch an auxiliary flag that ignores subtraction. A logic operation run after an overflowing compare catches stale carry and overflow bits. A cycle with the enable low catches a flags register that updates regardless of the enable.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    // bit 0 is carry, bit 5 is overflow
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } alu_flags_t;

    typedef struct packed {
        alu_flags_t flags;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             aux_o,
    output logic             ovf_o
);
    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [WIDTH:0]   ext;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        c_eff   = sub_i ? ~cin_i : cin_i;
        ext     = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
        sum_o   = ext[WIDTH-1:0];
        carry_o = ext[WIDTH] ^ sub_i;
        aux_o   = a_i[4] ^ b_i[4] ^ ext[4];
        ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (ext[WIDTH-1] != a_i[WIDTH-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        unique case (sel_i)
            2'b00:   y_o = a_i & b_i;
            2'b01:   y_o = a_i | b_i;
            2'b10:   y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
    parameter int WIDTH     = 32,
    parameter int PAR_BITS  = 8
) (
    input  logic [WIDTH-1:0] res_i,
    output logic             zero_o,
    output logic             sign_o,
    output logic             par_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        zero_o = (res_i == '0);
        sign_o = res_i[MSB];
        par_o  = ~^res_i[PAR_BITS-1:0];
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic [2:0]       opcode_i,
    input  logic             flag_we_i,
    output logic [WIDTH-1:0] result_o,
    output logic [5:0]       flags_o
);
    localparam int PAR_BITS = 8;

    alu_op_e    op;
    alu_state_t state_d, state_q;

    logic             is_sub, use_cin, is_logic, is_cmp;
    logic             as_cin;
    logic [WIDTH-1:0] as_sum, lg_y, res_int;
    logic             as_carry, as_aux, as_ovf;
    logic             ev_zero, ev_sign, ev_par;

    assign op = alu_op_e'(opcode_i);

    always_comb begin
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        is_cmp   = (op == OP_CMP);
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || is_cmp;
        use_cin  = (op == OP_ADC) || (op == OP_SBB);
        as_cin   = use_cin & state_q.flags.cry;
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .sub_i   (is_sub),
        .cin_i   (as_cin),
        .sum_o   (as_sum),
        .carry_o (as_carry),
        .aux_o   (as_aux),
        .ovf_o   (as_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (op_a_i),
        .b_i   (op_b_i),
        .sel_i (opcode_i[1:0]),
        .y_o   (lg_y)
    );

    assign res_int = is_logic ? lg_y : as_sum;

    alu_flag_eval #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_eval (
        .res_i  (res_int),
        .zero_o (ev_zero),
        .sign_o (ev_sign),
        .par_o  (ev_par)
    );

    always_comb begin
        state_d = state_q;
        if (flag_we_i) begin
            state_d.flags.cry = is_logic ? 1'b0 : as_carry;
            state_d.flags.ovf = is_logic ? 1'b0 : as_ovf;
            state_d.flags.aux = is_logic ? 1'b0 : as_aux;
            state_d.flags.zro = ev_zero;
            state_d.flags.sgn = ev_sign;
            state_d.flags.par = ev_par;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign result_o = is_cmp ? op_a_i : res_int;
    assign flags_o  = state_q.flags;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [WIDTH-1:0] op_a_i,
    input logic [2:0]       opcode_i,
    input logic             flag_we_i,
    input logic [WIDTH-1:0] result_o,
    input logic [5:0]       flags_o
);
    // R10
    hold_without_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_we_i |=> $stable(flags_o));

    // R8
    logic_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_we_i && (opcode_i == 3'd4 || opcode_i == 3'd5 || opcode_i == 3'd6))
        |=> (flags_o[0] == 1'b0 && flags_o[5] == 1'b0 && flags_o[2] == 1'b0));

    // R9
    cmp_keeps_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opcode_i == 3'd7) |-> (result_o == op_a_i));

    // R5
    zero_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_we_i && opcode_i != 3'd7) |=>
        (flags_o[3] == ($past(result_o) == '0) && flags_o[4] == $past(result_o[WIDTH-1])));

    // R7
    parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_we_i && opcode_i != 3'd7) |=> (flags_o[1] == ~^$past(result_o[7:0])));

    // R11
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (flags_o == 6'd0));
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
    localparam int W = 32;
    localparam int NV = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [2:0]   opc = 3'd0;
    logic         we = 1'b0;
    logic [W-1:0] res;
    logic [5:0]   flg;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flag_alu #(.WIDTH(W)) u_flag_alu (
        .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b),
        .opcode_i(opc), .flag_we_i(we), .result_o(res), .flags_o(flg)
    );

    // {opcode, a, b, expected result, expected flags}
    localparam logic [104:0] VEC [NV] = '{
        {3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 6'h36},
        {3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 6'h0F},
        {3'd1, 32'h0000_0005, 32'h0000_0003, 32'h0000_0009, 6'h02},
        {3'd2, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 6'h15},
        {3'd3, 32'h0000_000A, 32'h0000_0003, 32'h0000_0006, 6'h02},
        {3'd7, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 6'h26},
        {3'd4, 32'hF0F0_F0F3, 32'h0F0F_0FFF, 32'h0000_00F3, 6'h02},
        {3'd6, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 6'h0A},
        {3'd5, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001, 6'h10},
        {3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 6'h12},
        {3'd2, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 6'h17},
        {3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 6'h0F},
        {3'd3, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 6'h17}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y, input logic e);
        @(negedge clk);
        opc = o; a = x; b = y; we = e;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 flags in reset", {58'd0, flg}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [5:0] ef;
            drive(VEC[i][104:102], VEC[i][101:70], VEC[i][69:38], 1'b1);
            ef = VEC[i][5:0];
            #1;
            check($sformatf("R1 R9 result vec %0d", i), {32'd0, res}, {32'd0, VEC[i][37:6]});
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R3 carry vec %0d", i), {63'd0, flg[0]}, {63'd0, ef[0]});
            check($sformatf("R7 parity vec %0d", i), {63'd0, flg[1]}, {63'd0, ef[1]});
            check($sformatf("R6 aux vec %0d", i), {63'd0, flg[2]}, {63'd0, ef[2]});
            check($sformatf("R5 zero vec %0d", i), {63'd0, flg[3]}, {63'd0, ef[3]});
            check($sformatf("R5 sign vec %0d", i), {63'd0, flg[4]}, {63'd0, ef[4]});
            check($sformatf("R4 overflow vec %0d", i), {63'd0, flg[5]}, {63'd0, ef[5]});
        end

        // carry is now 1: plain add and subtract must ignore it
        drive(3'd0, 32'd1, 32'd1, 1'b0);
        #1 check("R2 add ignores carry", {32'd0, res}, 64'd2);
        drive(3'd2, 32'd5, 32'd1, 1'b0);
        #1 check("R2 sub ignores borrow", {32'd0, res}, 64'd4);

        // enable low: flags hold 0x17
        drive(3'd0, 32'hFFFF_FFFF, 32'd1, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R10 hold without enable", {58'd0, flg}, 64'h17);

        // logic op clears carry, overflow, aux
        drive(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R8 logic clears flags", {58'd0, flg}, 64'h12);

        // reset during operation
        we = 1'b0;
        rst_n = 1'b0;
        #1 check("R11 reset clears", {58'd0, flg}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end
endmodule